// File: doc/BRIEF.md
# Per-Requester Bandwidth Cap Regulator

This block sits on the request path of one processing element and holds its memory traffic to a programmed share of the bandwidth available to it. Each request carries a byte count. The block adds up the bytes it grants during a fixed window of cycles and compares the sum, including the request now waiting, against a byte budget. The budget is derived from a limit value held in a 64-bit configuration register. When the budget would be exceeded, the block closes the valid/ready handshake. A hard policy closes it unconditionally. A soft policy closes it only while the downstream path reports that it is saturated.

The limit is an unsigned fixed-point value with 16 fraction bits. Without hardware scaling it is a pure fraction of the available bandwidth. With scaling it gains a 16-bit integer part and acts as a multiplier. Only the top `FRAC_W` fraction bits are stored. A write to the register is visible on readback at once, but it steers regulation only from the next window boundary on.

Top module: `bwcap_regulator`

## Requirements
- R1: When the active enable bit (bit 62) is 0, `dn_valid_o` equals `up_valid_i` and `up_ready_o` equals `dn_ready_i` in every cycle.
- R2: With enable set and the policy bit (bit 61) at 1, a request is stalled (`dn_valid_o` = 0, `up_ready_o` = 0) whenever window usage plus `up_bytes_i` exceeds the byte budget. Otherwise it passes.
- R3: With enable set and the policy bit at 0, the over-budget stall applies only while `dn_sat_i` is 1. Otherwise the handshake passes through.
- R4: Without scaling, the budget is floor(`AVAIL_BYTES` × L / 65536), with L the value in bits [15:0]. Bits [31:16] read back as 0.
- R5: With scaling supported and bit 63 written as 1, bit 63 reads back as 1 and bits [31:0] form L = integer.fraction. The budget is again floor(`AVAIL_BYTES` × L / 65536).
- R6: Only the upper `FRAC_W` bits of bits [15:0] are kept. The lower 16−`FRAC_W` bits read as 0 and do not affect the budget.
- R7: Bits [60:32] always read as 0. Bit 63 reads as 0 when scaling support (`HAS_SCALE`) is absent.
- R8: Usage counts the bytes of every grant and returns to 0 after the last cycle of each window of `WINDOW_CYCLES` cycles. A grant in that last cycle is not carried into the next window, and a hard stall lifts once the cleared count plus the request fits.
- R9: A write shows on `cfg_rd_data_o` one cycle later. The enable, policy and budget it sets steer regulation only from the first cycle of the following window.
- R10: After reset the register reads 0 and the handshake passes through unregulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en_i | input | 1 | Write strobe for the configuration register |
| cfg_wr_data_i | input | 64 | Write data |
| cfg_rd_data_o | output | 64 | Stored register value with unimplemented bits at 0 |
| up_valid_i | input | 1 | Request valid from the processing element |
| up_bytes_i | input | BYTES_W | Byte count of the offered request |
| up_ready_o | output | 1 | Request accepted toward the requester |
| dn_valid_o | output | 1 | Request valid toward memory |
| dn_ready_i | input | 1 | Memory side can accept |
| dn_sat_i | input | 1 | Downstream path saturated |

## Verification
A wrong usage count or budget shows up as a stall or grant in the wrong cycle. It appears on `up_ready_o` and `dn_valid_o` within the same window, in the first cycle where an offered request crosses the true budget. A window counter out of phase moves the clearing of usage and the adoption of new settings. That becomes visible in the first window after a configuration change, because traffic that should pass is then blocked or traffic that should stop passes. Storage faults in the register appear on readback one cycle after the write.

// File: rtl/bwcap_pkg.sv
package bwcap_pkg;

  localparam int SCALE_BIT = 63;
  localparam int EN_BIT    = 62;
  localparam int HARD_BIT  = 61;

  typedef struct packed {
    logic en;
    logic hard;
  } bwcap_ctrl_t;

  // Keep only implemented bits of a written value.
  function automatic logic [63:0] cfg_sanitize(input logic [63:0] d,
                                               input bit has_scale,
                                               input int frac_w);
    logic [63:0] r;
    logic [15:0] keep;
    r = '0;
    r[EN_BIT]   = d[EN_BIT];
    r[HARD_BIT] = d[HARD_BIT];
    if (has_scale && d[SCALE_BIT]) begin
      r[SCALE_BIT] = 1'b1;
      r[31:16]     = d[31:16];
    end
    keep     = 16'(17'h0FFFF << (16 - frac_w));
    r[15:0]  = d[15:0] & keep;
    return r;
  endfunction

endpackage

// File: rtl/bwcap_cfg_reg.sv
module bwcap_cfg_reg
  import bwcap_pkg::*;
#(
  parameter bit HAS_SCALE = 1'b1,
  parameter int FRAC_W    = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [63:0] wr_data,
  input  logic        win_tick,
  output logic [63:0] rd_data,
  output bwcap_ctrl_t act_ctrl,
  output logic [31:0] pend_lim
);

  logic [63:0] shadow_q;
  logic [63:0] shadow_nxt;
  bwcap_ctrl_t act_q;

  always_comb begin
    shadow_nxt = wr_en ? cfg_sanitize(wr_data, HAS_SCALE, FRAC_W) : shadow_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      shadow_q <= shadow_nxt;
      if (win_tick) begin
        act_q.en   <= shadow_nxt[EN_BIT];
        act_q.hard <= shadow_nxt[HARD_BIT];
      end
    end
  end

  assign rd_data  = shadow_q;
  assign act_ctrl = act_q;
  assign pend_lim = shadow_nxt[31:0];

  assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (rst)
    rd_data[60:32] == '0);

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(win_tick) |-> $stable(act_q));

  assert_frac_hi_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_data[SCALE_BIT] |-> rd_data[31:16] == '0);

  generate
    if (FRAC_W < 16) begin : g_trunc_chk
      assert_frac_low_R6: assert property (@(posedge clk) disable iff (rst)
        rd_data[15-FRAC_W:0] == '0);
    end
    if (!HAS_SCALE) begin : g_noscale_chk
      assert_no_scale_R7: assert property (@(posedge clk) disable iff (rst)
        !rd_data[SCALE_BIT]);
    end
  endgenerate

endmodule

// File: rtl/bwcap_limit.sv
module bwcap_limit #(
  parameter bit HAS_SCALE   = 1'b1,
  parameter int AVAIL_BYTES = 64,
  parameter int AV_W        = $clog2(AVAIL_BYTES + 1),
  parameter int ALW_W       = AV_W + 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_tick,
  input  logic [31:0]      lim,
  output logic [ALW_W-1:0] allowed
);

  logic [ALW_W-1:0] budget;
  logic [ALW_W-1:0] allowed_q;

  generate
    if (HAS_SCALE) begin : g_mult
      localparam int PW = AV_W + 32;
      logic [PW-1:0] prod;
      assign prod   = PW'(AVAIL_BYTES) * PW'(lim);
      assign budget = prod[PW-1:16];
    end else begin : g_frac
      localparam int PW = AV_W + 16;
      logic [PW-1:0] prod;
      logic          unused_hi_bits;
      assign unused_hi_bits = ^lim[31:16];
      assign prod   = PW'(AVAIL_BYTES) * PW'(lim[15:0]);
      assign budget = ALW_W'(prod[PW-1:16]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           allowed_q <= '0;
    else if (win_tick) allowed_q <= budget;
  end

  assign allowed = allowed_q;

  assert_budget_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(win_tick) |-> $stable(allowed_q));

endmodule

// File: rtl/bwcap_window.sv
module bwcap_window #(
  parameter int WINDOW_CYCLES = 16,
  parameter int BYTES_W       = 6,
  parameter int WIN_W         = $clog2(WINDOW_CYCLES),
  parameter int USE_W         = BYTES_W + WIN_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               grant,
  input  logic [BYTES_W-1:0] grant_bytes,
  output logic               win_tick,
  output logic [USE_W-1:0]   usage
);

  logic [WIN_W-1:0] cnt_q;
  logic [USE_W-1:0] usage_q;

  assign win_tick = (cnt_q == WIN_W'(WINDOW_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      usage_q <= '0;
    end else begin
      cnt_q <= win_tick ? '0 : cnt_q + 1'b1;
      if (win_tick)   usage_q <= '0;
      else if (grant) usage_q <= usage_q + USE_W'(grant_bytes);
    end
  end

  assign usage = usage_q;

  assert_win_clear_R8: assert property (@(posedge clk) disable iff (rst)
    win_tick |=> usage_q == '0);

  assert_usage_mono_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(win_tick) |-> usage_q >= $past(usage_q));

endmodule

// File: rtl/bwcap_gate.sv
module bwcap_gate #(
  parameter int BYTES_W = 6,
  parameter int USE_W   = 11,
  parameter int ALW_W   = 23,
  parameter int CMP_W   = ((USE_W + 1) > ALW_W ? (USE_W + 1) : ALW_W) + 1
) (
  input  logic               en,
  input  logic               hard,
  input  logic               sat,
  input  logic [USE_W-1:0]   usage,
  input  logic [BYTES_W-1:0] bytes,
  input  logic [ALW_W-1:0]   allowed,
  input  logic               up_valid,
  input  logic               dn_ready,
  output logic               dn_valid,
  output logic               up_ready,
  output logic               grant
);

  logic [CMP_W-1:0] need;
  logic             over;
  logic             stall;

  always_comb begin
    need     = CMP_W'(usage) + CMP_W'(bytes);
    over     = need > CMP_W'(allowed);
    stall    = en && over && (hard || sat);
    dn_valid = up_valid && !stall;
    up_ready = dn_ready && !stall;
    grant    = up_valid && dn_ready && !stall;
  end

endmodule

// File: rtl/bwcap_regulator.sv
module bwcap_regulator
  import bwcap_pkg::*;
#(
  parameter bit HAS_SCALE     = 1'b1,
  parameter int FRAC_W        = 8,
  parameter int WINDOW_CYCLES = 16,
  parameter int AVAIL_BYTES   = 64,
  parameter int BYTES_W       = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr_en_i,
  input  logic [63:0]        cfg_wr_data_i,
  output logic [63:0]        cfg_rd_data_o,
  input  logic               up_valid_i,
  input  logic [BYTES_W-1:0] up_bytes_i,
  output logic               up_ready_o,
  output logic               dn_valid_o,
  input  logic               dn_ready_i,
  input  logic               dn_sat_i
);

  localparam int WIN_W = $clog2(WINDOW_CYCLES);
  localparam int USE_W = BYTES_W + WIN_W + 1;
  localparam int AV_W  = $clog2(AVAIL_BYTES + 1);
  localparam int ALW_W = AV_W + 16;

  logic             win_tick;
  logic [USE_W-1:0] usage;
  logic [ALW_W-1:0] allowed;
  logic [31:0]      pend_lim;
  bwcap_ctrl_t      act_ctrl;
  logic             grant;

  bwcap_cfg_reg #(.HAS_SCALE(HAS_SCALE), .FRAC_W(FRAC_W)) cfg_u (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en_i), .wr_data(cfg_wr_data_i),
    .win_tick(win_tick), .rd_data(cfg_rd_data_o), .act_ctrl(act_ctrl),
    .pend_lim(pend_lim)
  );

  bwcap_limit #(.HAS_SCALE(HAS_SCALE), .AVAIL_BYTES(AVAIL_BYTES),
                .AV_W(AV_W), .ALW_W(ALW_W)) limit_u (
    .clk(clk), .rst(rst), .win_tick(win_tick), .lim(pend_lim),
    .allowed(allowed)
  );

  bwcap_window #(.WINDOW_CYCLES(WINDOW_CYCLES), .BYTES_W(BYTES_W),
                 .WIN_W(WIN_W), .USE_W(USE_W)) win_u (
    .clk(clk), .rst(rst), .grant(grant), .grant_bytes(up_bytes_i),
    .win_tick(win_tick), .usage(usage)
  );

  bwcap_gate #(.BYTES_W(BYTES_W), .USE_W(USE_W), .ALW_W(ALW_W)) gate_u (
    .en(act_ctrl.en), .hard(act_ctrl.hard), .sat(dn_sat_i),
    .usage(usage), .bytes(up_bytes_i), .allowed(allowed),
    .up_valid(up_valid_i), .dn_ready(dn_ready_i),
    .dn_valid(dn_valid_o), .up_ready(up_ready_o), .grant(grant)
  );

  assert_passthru_R1: assert property (@(posedge clk) disable iff (rst)
    !act_ctrl.en |-> (dn_valid_o == up_valid_i) && (up_ready_o == dn_ready_i));

  assert_hard_cap_R2: assert property (@(posedge clk) disable iff (rst)
    (act_ctrl.en && act_ctrl.hard && up_valid_i && up_ready_o) |->
      (40'(usage) + 40'(up_bytes_i) <= 40'(allowed)));

  assert_soft_free_R3: assert property (@(posedge clk) disable iff (rst)
    (act_ctrl.en && !act_ctrl.hard && !dn_sat_i) |->
      (up_ready_o == dn_ready_i) && (dn_valid_o == up_valid_i));

  assert_reset_state_R10: assert property (@(posedge clk)
    $past(rst) |-> cfg_rd_data_o == '0 && !act_ctrl.en);

endmodule

// File: tb/bwcap_regulator_tb_top.sv
`timescale 1ns/1ps
module bwcap_regulator_tb_top;

  localparam int WIN   = 16;
  localparam int AVAIL = 64;
  localparam int FW    = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [63:0] wd = '0;
  logic [63:0] rd, rd_ns;
  logic        uv = 1'b0, dr = 1'b0, sat = 1'b0;
  logic [5:0]  ub = '0;
  logic        ur, dv, ns_ur, ns_dv;

  always #4 clk = ~clk;

  bwcap_regulator dut_i (
    .clk(clk), .rst(rst), .cfg_wr_en_i(we), .cfg_wr_data_i(wd),
    .cfg_rd_data_o(rd), .up_valid_i(uv), .up_bytes_i(ub), .up_ready_o(ur),
    .dn_valid_o(dv), .dn_ready_i(dr), .dn_sat_i(sat)
  );

  bwcap_regulator #(.HAS_SCALE(1'b0)) dut_ns_i (
    .clk(clk), .rst(rst), .cfg_wr_en_i(we), .cfg_wr_data_i(wd),
    .cfg_rd_data_o(rd_ns), .up_valid_i(uv), .up_bytes_i(ub), .up_ready_o(ns_ur),
    .dn_valid_o(ns_dv), .dn_ready_i(dr), .dn_sat_i(sat)
  );

  int vectors = 0;
  int miscompares = 0;
  string cur_tag = "R10";

  int          m_win = 0;
  longint      m_use = 0;
  longint      m_allowed = 0;
  bit          m_en = 0, m_hard = 0;
  logic [63:0] m_shadow = '0, m_shadow_ns = '0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [63:0] exp_store(input logic [63:0] d, input bit hs);
    logic [63:0] r = '0;
    r[62] = d[62];
    r[61] = d[61];
    if (hs && d[63]) begin
      r[63] = 1'b1;
      r[31:16] = d[31:16];
    end
    for (int i = 16 - FW; i < 16; i++) r[i] = d[i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at t=%0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic step(input bit v, input logic [5:0] b, input bit r, input bit s,
                      input bit w, input logic [63:0] d);
    bit stall, g;
    logic [63:0] nxt;
    uv = v; ub = b; dr = r; sat = s; we = w; wd = d;
    #1;
    check("R7", rd, m_shadow);
    check("R7", rd_ns, m_shadow_ns);
    stall = m_en && ((m_use + longint'(b)) > m_allowed) && (m_hard || s);
    check(cur_tag, {63'b0, dv}, {63'b0, v && !stall});
    check(cur_tag, {63'b0, ur}, {63'b0, r && !stall});
    g = v && r && !stall;
    @(posedge clk);
    nxt = w ? exp_store(d, 1'b1) : m_shadow;
    if (w) m_shadow_ns = exp_store(d, 1'b0);
    if (m_win == WIN - 1) begin
      m_use     = 0;
      m_en      = nxt[62];
      m_hard    = nxt[61];
      m_allowed = (longint'(AVAIL) * longint'(nxt[31:0])) >> 16;
    end else if (g) begin
      m_use += longint'(b);
    end
    m_shadow = nxt;
    m_win = (m_win + 1) % WIN;
    @(negedge clk);
  endtask

  task automatic traffic(input int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[6] | lfsr[7], lfsr[5:0], lfsr[8] | lfsr[9] | lfsr[11], lfsr[10],
           1'b0, 64'h0);
    end
  endtask

  function automatic logic [31:0] lim_of(input int i, input bit sc);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_1000;
      2: return 32'h0000_4000;
      3: return 32'h0000_8000;
      4: return 32'h0000_FFFF;
      5: return 32'h0000_00FF;
      6: return 32'h0003_80FF;
      7: return sc ? 32'h0001_0000 : 32'h0001_2000;
      8: return 32'h0002_8000;
      default: return 32'h0000_C07F;
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state reads zero and traffic passes unregulated.
    cur_tag = "R10";
    check("R10", rd, 64'h0);
    step(1, 6'd63, 1, 1, 0, 0);
    step(1, 6'd40, 0, 1, 0, 0);
    step(0, 6'd5, 1, 0, 0, 0);

    // R9: write a hard zero budget just after a boundary; old setting stays.
    while (m_win != 1) step(0, 0, 0, 0, 0, 0);
    cur_tag = "R9";
    step(1, 6'd10, 1, 0, 1, {3'b011, 29'h0, 32'h0});
    for (int i = 0; i < WIN; i++) step(1, 6'd10, 1, 0, 0, 0);
    // Now in the new window every nonzero request stalls.
    for (int i = 0; i < 4; i++) step(1, 6'd1, 1, 0, 0, 0);

    // R8: hard budget of 32 bytes, 12-byte requests, stall then release.
    while (m_win != 1) step(0, 0, 0, 0, 0, 0);
    cur_tag = "R8";
    step(0, 0, 0, 0, 1, {3'b011, 29'h0, 32'h0000_8000});
    while (m_win != 0) step(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 2 * WIN + 3; i++) step(1, 6'd12, 1, 0, 0, 0);
    // A zero-byte request always fits.
    step(1, 6'd0, 1, 0, 0, 0);

    // Sweep of enable, policy, scaling and limit values.
    for (int sc = 0; sc < 2; sc++)
      for (int en = 0; en < 2; en++)
        for (int hd = 0; hd < 2; hd++)
          for (int li = 0; li < 10; li++) begin
            logic [31:0] lv;
            lv = lim_of(li, sc[0]);
            if (en == 0)      cur_tag = "R1";
            else if (hd == 0) cur_tag = "R3";
            else if (sc == 1) cur_tag = "R5";
            else if (lv[7:0] != 0) cur_tag = "R6";
            else if (li % 2 == 0)  cur_tag = "R4";
            else                   cur_tag = "R2";
            step(0, 0, 0, 0, 1, {sc[0], en[0], hd[0], 29'h1FFF_FFFF, lv});
            traffic(40);
          end

    // R7: write all ones; reserved bits and unsupported scale read zero.
    cur_tag = "R7";
    step(0, 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R7", {35'b0, rd[60:32]}, 64'h0);
    check("R7", {63'b0, rd_ns[63]}, 64'h0);
    check("R4", {48'b0, rd_ns[31:16]}, 64'h0);
    check("R6", {56'b0, rd[7:0]}, 64'h0);
    traffic(20);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule